// File: doc/BRIEF.md
# Bus Handshake and Termination Rule Monitor

This block watches the control lines of a shared parallel bus with a multiplexed address and data path, such as PCI. It never drives the bus. On every rising clock edge it samples the active-low framing, initiator-ready, target-ready, stop and device-select lines, together with the command nibble. From the pattern of the framing and initiator-ready lines it works out the bus phase: idle, address, data, last data or turnaround. It then checks a fixed set of ordering rules that govern how a transfer is handshaken and how it ends.

Each rule has its own sticky flag, which stays set until reset. A separate strobe pulses for one cycle whenever any rule is broken. A flag or the strobe rises in the clock cycle after the edge at which the offending pattern was sampled. The monitor is meant to sit beside a bus model in simulation or on a debug build of a chip, where it reports protocol mistakes made by initiators or targets.

A data transfer completes on any edge where initiator-ready and target-ready are both active. The last data phase is any cycle in which framing is inactive and initiator-ready is active. A transaction is finished once that phase ends through target-ready or stop.

Top module: `pci_term_monitor`

## Requirements
- R1: Flag bit 0 rises when device-select goes from active to inactive while the transaction is unfinished. It does not rise when the previous edge completed the last data phase, or when stop is active at the current or the previous edge.
- R2: Flag bit 1 rises when target-ready is active at the edge right after an address phase whose command is a read. A command counts as a read when its bit 0 is low, except the reserved codes 4'b0100 and 4'b1000. A write (bit 0 high) or a reserved code in that position is never flagged.
- R3: Flag bit 2 rises when stop and framing both go from active to inactive at the same edge.
- R4: Flag bit 3 rises when stop goes from active to inactive while framing stays active across both edges.
- R5: Flag bit 4 rises when initiator-ready is withdrawn and the previous edge saw neither target-ready nor stop active. A master abort is exempt: framing was already inactive at the previous edge and device-select was never active during the transaction.
- R6: Flag bit 5 rises when framing goes from active to inactive and initiator-ready is inactive at that same edge.
- R7: Flag bit 6 rises when, at the edge after the last data phase completed, any of initiator-ready, target-ready or stop is still active.
- R8: Flag bit 7 rises when target-ready is active together with stop active and device-select inactive (target abort).
- R9: Reset clears all flags and the strobe. A set flag stays set through any later bus activity until the next reset.
- R10: The strobe is high for exactly one cycle after each edge at which at least one rule is broken. This includes repeats of a rule already flagged. It is low after every other edge.
- R11: Well-formed traffic raises no flag and no strobe. This covers normal completion, target disconnect or retry, target abort, master abort, fast or slow device select, and wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all lines sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Framing line, active low |
| irdy_n | input | 1 | Initiator-ready line, active low |
| trdy_n | input | 1 | Target-ready line, active low |
| stop_n | input | 1 | Target stop request, active low |
| devsel_n | input | 1 | Device-select line, active low |
| cbe_n | input | 4 | Command / byte-enable nibble; command meaning only in the address phase |
| err_flags | output | 8 | Sticky per-rule flags, bit index as listed in R1 to R8 |
| err_pulse | output | 1 | One-cycle strobe for each edge with a violation |

## Verification
The assertions assume that every monitored line holds a defined level at each sampling edge. They also assume that the bus is idle, with all lines inactive, at the edge before reset is released, because several rules compare against the previous sample. The stimulus holds every line inactive throughout reset and changes inputs only on the falling clock edge. It also leaves at least one idle cycle between transactions. Legal transactions are built by a generator that follows the handshake rules: initiator-ready stays asserted until completion, framing drops before the last phase, and device-select is held until after the final transfer. Each rule break is then injected on its own from a clean state.

// File: rtl/pci_term_pkg.sv
// Package: shared types and constants for the bus termination monitor.
// Assumes a 4-bit command nibble and eight independent rule checks.
package pci_term_pkg;

    localparam int CMD_W  = 4;
    localparam int RD_IDX = 0;
    localparam int N_RULE = 8;

    // Bit positions of the per-rule flags (visible at the top ports)
    localparam int RULE_SEL_DROP    = 0;
    localparam int RULE_RD_TURN     = 1;
    localparam int RULE_STOP_FRAME  = 2;
    localparam int RULE_STOP_BOUNCE = 3;
    localparam int RULE_IRDY_EARLY  = 4;
    localparam int RULE_IRDY_LAST   = 5;
    localparam int RULE_END_DIRTY   = 6;
    localparam int RULE_TABORT_TRDY = 7;

    // Reserved command codes that look like reads by bit 0 alone
    localparam logic [CMD_W-1:0] CMD_RSV_A = 4'b0100;
    localparam logic [CMD_W-1:0] CMD_RSV_B = 4'b1000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_LAST,
        PH_TURN
    } phase_e;

    // Control lines converted to active-high
    typedef struct packed {
        logic frame;
        logic irdy;
        logic trdy;
        logic stop;
        logic devsel;
    } ctl_t;

    // Registered context handed from the phase tracker to the rule logic
    typedef struct packed {
        ctl_t   prev;
        phase_e p_phase;
        logic   rd_q;
        logic   sel_seen;
    } ctx_t;

endpackage

// File: rtl/pci_bus_phase.sv
// Module: pci_bus_phase
// Derives the current bus phase from the framing/initiator-ready pattern
// and keeps the context the rules need: the previous sample, the previous
// phase, the read class of the current command and whether device-select
// was seen since the address phase.
// Assumes inputs are already synchronous and converted to active-high.
module pci_bus_phase
    import pci_term_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             cur,
    input  logic [CMD_W-1:0] cmd_n,
    output phase_e           phase,
    output ctx_t             ctx
);

    ctl_t   prev_q;
    phase_e phase_q;
    logic   rd_q;
    logic   sel_seen_q;
    logic   is_read;

    // Classify the current bus phase from this and the previous sample
    always_comb begin
        if (cur.frame && !prev_q.frame)
            phase = PH_ADDR;
        else if (cur.frame)
            phase = PH_DATA;
        else if (cur.irdy)
            phase = PH_LAST;
        else if (prev_q.frame || prev_q.irdy)
            phase = PH_TURN;
        else
            phase = PH_IDLE;
    end

    // Read class: bit 0 low, reserved look-alikes excluded
    always_comb begin
        is_read = !cmd_n[RD_IDX] && (cmd_n != CMD_RSV_A) && (cmd_n != CMD_RSV_B);
    end

    // Hold the previous sample and phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            phase_q <= PH_IDLE;
        end else begin
            prev_q  <= cur;
            phase_q <= phase;
        end
    end

    // Latch read class at the address phase, track device-select since then
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q       <= 1'b0;
            sel_seen_q <= 1'b0;
        end else if (phase == PH_ADDR) begin
            rd_q       <= is_read;
            sel_seen_q <= cur.devsel;
        end else begin
            sel_seen_q <= sel_seen_q | cur.devsel;
        end
    end

    assign ctx.prev     = prev_q;
    assign ctx.p_phase  = phase_q;
    assign ctx.rd_q     = rd_q;
    assign ctx.sel_seen = sel_seen_q;

endmodule

// File: rtl/pci_rule_eval.sv
// Module: pci_rule_eval
// Purely combinational evaluation of the eight ordering rules from the
// present sample and the registered context. One output bit per rule.
// Assumes ctx reflects the sample taken at the previous edge.
module pci_rule_eval
    import pci_term_pkg::*;
(
    input  ctl_t              cur,
    input  phase_e            phase,
    input  ctx_t              ctx,
    output logic [N_RULE-1:0] viol
);

    ctl_t p;
    logic p_done;
    logic p_addr;
    logic mabort_ok;
    logic stop_fell;

    assign p = ctx.prev;

    // Shared terms: last phase finished, previous edge was address, etc.
    always_comb begin
        p_done    = (ctx.p_phase == PH_LAST) && (p.trdy || p.stop);
        p_addr    = (ctx.p_phase == PH_ADDR);
        mabort_ok = !p.frame && !ctx.sel_seen;
        stop_fell = p.stop && !cur.stop;
    end

    // One term per rule
    always_comb begin
        viol = '0;
        viol[RULE_SEL_DROP]    = p.devsel && !cur.devsel && !p.stop && !cur.stop && !p_done;
        viol[RULE_RD_TURN]     = p_addr && ctx.rd_q && cur.trdy && (phase != PH_ADDR);
        viol[RULE_STOP_FRAME]  = stop_fell && p.frame && !cur.frame;
        viol[RULE_STOP_BOUNCE] = stop_fell && p.frame && cur.frame;
        viol[RULE_IRDY_EARLY]  = p.irdy && !cur.irdy && !p.trdy && !p.stop && !mabort_ok;
        viol[RULE_IRDY_LAST]   = p.frame && !cur.frame && !cur.irdy;
        viol[RULE_END_DIRTY]   = p_done && (cur.irdy || cur.trdy || cur.stop);
        viol[RULE_TABORT_TRDY] = cur.stop && !cur.devsel && cur.trdy;
    end

endmodule

// File: rtl/pci_err_log.sv
// Module: pci_err_log
// Keeps one sticky flag per rule and a one-cycle strobe for each edge at
// which any rule is broken.
// Assumes viol is valid at every edge once reset is released.
module pci_err_log #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] viol,
    output logic [N-1:0] flags,
    output logic         pulse
);

    // One sticky bit per rule
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (viol[g])
                flag_q <= 1'b1;
        end
        assign flags[g] = flag_q;
    end

    // Strobe for any violation at this edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= 1'b0;
        else
            pulse <= |viol;
    end

endmodule

// File: rtl/pci_term_monitor.sv
// Module: pci_term_monitor (top)
// Passive monitor of bus handshake and termination ordering. Converts the
// active-low lines to active-high, tracks the bus phase, evaluates the
// rules and records violations.
// Assumes all inputs are synchronous to clk and never driven by this block.
module pci_term_monitor
    import pci_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    input  logic              devsel_n,
    input  logic [CMD_W-1:0]  cbe_n,
    output logic [N_RULE-1:0] err_flags,
    output logic              err_pulse
);

    ctl_t              cur;
    phase_e            phase;
    ctx_t              ctx;
    logic [N_RULE-1:0] viol;

    // Active-high view of the sampled lines
    assign cur.frame  = ~frame_n;
    assign cur.irdy   = ~irdy_n;
    assign cur.trdy   = ~trdy_n;
    assign cur.stop   = ~stop_n;
    assign cur.devsel = ~devsel_n;

    pci_bus_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (cur),
        .cmd_n (cbe_n),
        .phase (phase),
        .ctx   (ctx)
    );

    pci_rule_eval u_rules (
        .cur   (cur),
        .phase (phase),
        .ctx   (ctx),
        .viol  (viol)
    );

    pci_err_log #(.N(N_RULE)) u_log (
        .clk   (clk),
        .rst_n (rst_n),
        .viol  (viol),
        .flags (err_flags),
        .pulse (err_pulse)
    );

endmodule

// File: rtl/pci_term_monitor_chk.sv
// Module: pci_term_monitor_chk
// Port-level properties of the monitor, attached by bind below.
// Assumes the bus is idle at the edge before reset is released.
module pci_term_monitor_chk
    import pci_term_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              trdy_n,
    input logic              stop_n,
    input logic              devsel_n,
    input logic [CMD_W-1:0]  cbe_n,
    input logic [N_RULE-1:0] err_flags,
    input logic              err_pulse
);

    logic rd_cmd;
    assign rd_cmd = !cbe_n[RD_IDX] && (cbe_n != CMD_RSV_A) && (cbe_n != CMD_RSV_B);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (err_flags == '0 && !err_pulse)); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err_flags & $past(err_flags)) == $past(err_flags)); // R9
    AST_PULSE_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n) (err_flags != $past(err_flags)) |-> err_pulse); // R10
    AST_RD_TURN: assert property (@(posedge clk) disable iff (!rst_n) (!frame_n && $past(frame_n) && rd_cmd) ##1 (!trdy_n && !frame_n) |=> err_flags[RULE_RD_TURN]); // R2
    AST_STOP_FRAME: assert property (@(posedge clk) disable iff (!rst_n) ($past(!stop_n && !frame_n) && stop_n && frame_n) |=> err_flags[RULE_STOP_FRAME]); // R3
    AST_IRDY_LAST: assert property (@(posedge clk) disable iff (!rst_n) ($past(!frame_n) && frame_n && irdy_n) |=> err_flags[RULE_IRDY_LAST]); // R6
    AST_TABORT_TRDY: assert property (@(posedge clk) disable iff (!rst_n) (!stop_n && devsel_n && !trdy_n) |=> (err_flags[RULE_TABORT_TRDY] && err_pulse)); // R8

endmodule

bind pci_term_monitor pci_term_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .devsel_n  (devsel_n),
    .cbe_n     (cbe_n),
    .err_flags (err_flags),
    .err_pulse (err_pulse)
);

// File: tb/pci_term_monitor_bench.sv
`timescale 1ns/1ps
module pci_term_monitor_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, devsel_n = 1'b1;
    logic [3:0] cbe_n = 4'hF;
    logic [7:0] err_flags;
    logic       err_pulse;

    int total = 0;
    int bad = 0;
    int pulse_cnt = 0;

    always #10 clk = ~clk;

    pci_term_monitor u_pci_term_monitor (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n), .cbe_n(cbe_n),
        .err_flags(err_flags), .err_pulse(err_pulse)
    );

    function automatic logic [7:0] exp_mask(input int rule);
        return 8'(1 << rule);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // One bus clock: set lines (active-high args), sample strobe after the edge
    task automatic cyc(input bit f, input bit i, input bit t, input bit s, input bit d);
        frame_n = ~f; irdy_n = ~i; trdy_n = ~t; stop_n = ~s; devsel_n = ~d;
        @(negedge clk);
        if (err_pulse === 1'b1) pulse_cnt++;
        cbe_n = 4'h0;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0);
    endtask

    task automatic addr(input logic [3:0] cmd);
        cbe_n = cmd;
        cyc(1, 0, 0, 0, 0);
    endtask

    task automatic bus_reset();
        rst_n = 1'b0;
        frame_n = 1; irdy_n = 1; trdy_n = 1; stop_n = 1; devsel_n = 1; cbe_n = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pulse_cnt = 0;
    endtask

    // Inject a single break of the given rule from an idle bus
    task automatic drive_rule(input int r);
        case (r)
            0: begin addr(4'b0110); cyc(1,1,0,0,1); cyc(1,1,0,0,1); cyc(1,1,0,0,0); cyc(0,1,1,0,0); idle(); end
            1: begin addr(4'b0110); cyc(0,1,1,0,1); idle(); end
            2: begin addr(4'b0111); cyc(1,1,0,0,1); cyc(1,1,0,1,1); cyc(0,1,1,0,1); idle(); end
            3: begin addr(4'b0111); cyc(1,1,0,0,1); cyc(1,1,0,1,1); cyc(1,1,0,0,1); cyc(0,1,1,0,1); idle(); end
            4: begin addr(4'b0111); cyc(1,1,0,0,1); cyc(1,0,0,0,1); cyc(0,1,1,0,1); idle(); end
            5: begin addr(4'b0111); cyc(1,1,1,0,1); cyc(0,0,0,0,1); cyc(0,1,1,0,1); idle(); end
            6: begin addr(4'b0111); cyc(0,1,1,0,1); cyc(0,0,1,0,0); idle(); end
            default: begin addr(4'b0111); cyc(1,1,0,0,1); cyc(1,1,1,1,0); cyc(0,1,0,1,0); idle(); end
        endcase
        idle();
    endtask

    // Well-formed transaction; term: 0 normal, 1 disconnect, 2 target abort, 3 master abort
    task automatic legal_txn(input bit rd, input int nd, input int dly, input int term);
        int done = 0;
        int t = 1;
        int stop_at = int'($urandom % nd);
        addr(rd ? 4'b0110 : 4'b0111);
        if (term == 3) begin
            repeat (3) cyc(1,1,0,0,0);
            cyc(0,1,0,0,0);
            idle();
            return;
        end
        while (done < nd) begin
            bit f = (nd - done) > 1;
            bit d = (t >= dly);
            bit tr;
            if (term != 0 && done == stop_at && d) begin
                if (term == 1) begin
                    cyc(f,1,0,1,1);
                    if (f) cyc(0,1,0,1,1);
                end else begin
                    cyc(f,1,0,1,0);
                    if (f) cyc(0,1,0,1,0);
                end
                break;
            end
            tr = d && !(rd && t == 1) && ($urandom % 3 != 0);
            cyc(f,1,tr,0,d);
            if (tr) done++;
            t++;
        end
        idle();
        if ($urandom % 2 == 1) idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        bus_reset();
        // R9: reset state
        chk("R9 flags after reset", 32'(err_flags), 0);
        chk("R9 strobe after reset", 32'(err_pulse), 0);

        // R1..R8: each rule broken alone
        for (int r = 0; r < 8; r++) begin
            bus_reset();
            drive_rule(r);
            case (r)
                0: chk("R1 flag", 32'(err_flags), 32'(exp_mask(0)));
                1: chk("R2 flag", 32'(err_flags), 32'(exp_mask(1)));
                2: chk("R3 flag", 32'(err_flags), 32'(exp_mask(2)));
                3: chk("R4 flag", 32'(err_flags), 32'(exp_mask(3)));
                4: chk("R5 flag", 32'(err_flags), 32'(exp_mask(4)));
                5: chk("R6 flag", 32'(err_flags), 32'(exp_mask(5)));
                6: chk("R7 flag", 32'(err_flags), 32'(exp_mask(6)));
                default: chk("R8 flag", 32'(err_flags), 32'(exp_mask(7)));
            endcase
            chk("R10 one strobe per break", 32'(pulse_cnt), 1);
        end

        // R2: write or reserved code with target-ready after address is legal
        bus_reset();
        addr(4'b0111); cyc(0,1,1,0,1); idle();
        addr(4'b0100); cyc(0,1,1,0,1); idle();
        addr(4'b1000); cyc(0,1,1,0,1); idle(); idle();
        chk("R2 write/reserved not flagged", 32'(err_flags), 0);

        // R9: sticky through traffic, cleared by reset
        bus_reset();
        drive_rule(3);
        repeat (4) legal_txn(1'b0, 2, 1, 0);
        chk("R9 flag stays", 32'(err_flags), 32'(exp_mask(3)));
        bus_reset();
        chk("R9 flag cleared", 32'(err_flags), 0);

        // R10: repeated break of the same rule strobes twice
        bus_reset();
        drive_rule(6);
        drive_rule(6);
        chk("R10 repeat strobes", 32'(pulse_cnt), 2);
        chk("R10 single flag", 32'(err_flags), 32'(exp_mask(6)));

        // R11 (and R5 master-abort exemption): random legal traffic per ending
        for (int tm = 0; tm < 4; tm++) begin
            bus_reset();
            repeat (15) legal_txn(1'($urandom % 2), 1 + int'($urandom % 4), 1 + int'($urandom % 3), tm);
            if (tm == 3) chk("R5 master abort exempt", 32'(err_flags), 0);
            else         chk("R11 legal traffic flags", 32'(err_flags), 0);
            chk("R11 legal traffic strobes", 32'(pulse_cnt), 0);
        end

        // Mixed: random legal history then one random break
        for (int k = 0; k < 8; k++) begin
            int rr = int'($urandom % 8);
            bus_reset();
            repeat (10) legal_txn(1'($urandom % 2), 1 + int'($urandom % 4), 1 + int'($urandom % 3), int'($urandom % 4));
            drive_rule(rr);
            chk("R11 mixed break flag", 32'(err_flags), 32'(exp_mask(rr)));
            chk("R10 mixed break strobe", 32'(pulse_cnt), 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule